// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block is a full-duplex serial port that exchanges fixed-size characters (eight bits by default) over a data-out line, a data-in line and a single shared serial clock. Transmit and receive each keep a holding register in front of a shift register. Software can therefore queue the next outgoing character, or collect the last incoming one, while a transfer is still running, and characters follow each other with no idle gap.

The serial clock has two sources. It can come from an on-chip divider, in which case the block drives it out and produces exactly one pulse per bit. It can also come from an external clock pin, which is first synchronised into the system clock domain. A small register interface gives the host the transmit and receive data, three status flags (transmit holding register empty, receive holding register full, overrun), the divisor, and the enables and clock-source selection. A receive-only mode with the internal clock keeps the clock running so that characters stream in continuously.

Top module: `sync_serial_port`

## Requirements
- R1: Register map on the 3-bit host address: 0 = transmit data (write), 1 = receive data (read; a read pulse clears the full flag), 2 = status (bit0 transmit empty, bit1 receive full, bit2 overrun), 3 = divisor N, 4 = control (bit0 transmit enable, bit1 receive enable, bit2 external clock). After reset, status reads 0x01, the serial clock output is 1, the data output is 1 and the clock output enable is 1.
- R2: Each character has exactly eight data bits and is sent least significant bit first, with no added parity or address bit.
- R3: The data output changes only on a falling edge of the serial clock and holds its value until the next falling edge.
- R4: Received bits are sampled on rising serial-clock edges, least significant bit first. After the eighth rising edge the character appears at address 1 and status bit1 is set.
- R5: After the last bit of a character, when no further character is queued, the data output keeps the value of the most significant bit.
- R6: With the internal clock (control bit2 = 0), the clock output enable is 1 and the block emits exactly eight clock pulses per character.
- R7: The serial clock output rests at 1 whenever no character is in transfer.
- R8: Transmit and receive run on the same clock pulses at once: one character goes out while another comes in.
- R9: The internal serial clock period is 2×(N+1) system clock cycles, where N is the divisor register.
- R10: Status bit0 sets when the transmit holding register moves into the shifter. A character written during a transfer follows the current one with a clock period equal to the normal period and no gap.
- R11: A character that completes while status bit1 is still set is discarded: status bit2 sets and the receive data register keeps its old value.
- R12: The overrun flag stays set until the host writes address 2 with bit2 = 1. Reads, and writes with bit2 = 0, leave it set.
- R13: With control bit2 = 1, the clock input pin drives both shifters, the clock output enable is 0 and the internal divider emits no pulses.
- R14: With the internal clock, receive enabled and transmit disabled, the clock runs continuously and characters are received back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational on address) |
| sck_i | input | 1 | External serial clock input |
| sck_o | output | 1 | Serial clock output |
| sck_oe | output | 1 | Serial clock output enable (1 with the internal clock) |
| txd_o | output | 1 | Serial data output |
| rxd_i | input | 1 | Serial data input |

## Verification
The bench acts as the far end of the link. It checks bit order in both directions with asymmetric patterns, and it checks the level the data line holds after a character ending in 0 and after one ending in 1. A design that sent MSB first, or that returned the line to a fixed level, would produce the wrong captured byte or the wrong idle line. The bench measures the gap between the last pulse of one character and the first pulse of the next when the second character is queued mid-transfer; a design that inserted a gap or restarted the divider would give an oversized period. It forces an overrun and checks that the old byte survives and that only an explicit clear with bit2 set removes the flag. Further tests cover divisor zero, receive-only streaming and the external clock source, where a design still driving the pin or still pulsing internally would be caught.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
   localparam int unsigned HOST_AW = 3;
   localparam int unsigned HOST_DW = 8;

   typedef enum logic [HOST_AW-1:0] {
      REG_TXD  = 3'd0,
      REG_RXD  = 3'd1,
      REG_STAT = 3'd2,
      REG_DIV  = 3'd3,
      REG_CTRL = 3'd4
   } ssp_reg_e;

   localparam int unsigned STAT_TDE = 0;
   localparam int unsigned STAT_RDF = 1;
   localparam int unsigned STAT_OVR = 2;

   // packed so that bit0 = transmit enable, bit1 = receive enable, bit2 = external clock
   typedef struct packed {
      logic ext;
      logic rxe;
      logic txe;
   } ssp_ctrl_t;
endpackage

// File: rtl/ssp_regs.sv
module ssp_regs
   import ssp_pkg::*;
#(
   parameter int unsigned CHAR_BITS = 8,
   parameter int unsigned DIV_W     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [HOST_AW-1:0]   addr,
   input  logic [HOST_DW-1:0]   wdata,
   output logic [HOST_DW-1:0]   rdata,
   input  logic [CHAR_BITS-1:0] rx_char,
   input  logic                 tde,
   input  logic                 rdf,
   input  logic                 ovr,
   output logic                 tdr_wr,
   output logic                 rdr_rd,
   output logic                 ovr_clr,
   output logic [DIV_W-1:0]     div,
   output ssp_ctrl_t            ctrl
);
   assign tdr_wr  = wr_en && (addr == REG_TXD);
   assign rdr_rd  = rd_en && (addr == REG_RXD);
   assign ovr_clr = wr_en && (addr == REG_STAT) && wdata[STAT_OVR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div  <= '0;
         ctrl <= '0;
      end else if (wr_en) begin
         if (addr == REG_DIV)  div  <= wdata[DIV_W-1:0];
         if (addr == REG_CTRL) ctrl <= ssp_ctrl_t'(wdata[2:0]);
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         REG_RXD:  rdata[CHAR_BITS-1:0] = rx_char;
         REG_STAT: begin
            rdata[STAT_TDE] = tde;
            rdata[STAT_RDF] = rdf;
            rdata[STAT_OVR] = ovr;
         end
         REG_DIV:  rdata[DIV_W-1:0] = div;
         REG_CTRL: rdata[2:0] = ctrl;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
   parameter int unsigned CHAR_BITS   = 8,
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          EXT_CLK_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_sel,
   input  logic             req,
   input  logic [DIV_W-1:0] div,
   input  logic             sck_in,
   output logic             sck_out,
   output logic             fall_stb,
   output logic             rise_stb
);
   localparam int unsigned PW = $clog2(CHAR_BITS + 1);
   localparam logic [PW-1:0] LAST_PULSE = PW'(CHAR_BITS);

   logic             act;
   logic             sclk_q;
   logic [DIV_W-1:0] cnt;
   logic [PW-1:0]    npul;
   logic             go, tick, i_fall, i_rise;
   logic             e_fall, e_rise;

   assign go     = req && !ext_sel;
   assign tick   = act && (cnt == div);
   assign i_fall = (!act && go) || (tick && sclk_q && ((npul != LAST_PULSE) || go));
   assign i_rise = tick && !sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act    <= 1'b0;
         sclk_q <= 1'b1;
         cnt    <= '0;
         npul   <= '0;
      end else if (!act) begin
         if (go) begin
            act    <= 1'b1;
            sclk_q <= 1'b0;
            cnt    <= '0;
            npul   <= PW'(1);
         end
      end else if (!tick) begin
         cnt <= cnt + 1'b1;
      end else begin
         cnt <= '0;
         if (!sclk_q) begin
            sclk_q <= 1'b1;
         end else if (npul != LAST_PULSE) begin
            sclk_q <= 1'b0;
            npul   <= npul + 1'b1;
         end else if (go) begin
            sclk_q <= 1'b0;
            npul   <= PW'(1);
         end else begin
            act <= 1'b0;
         end
      end
   end

   generate
      if (EXT_CLK_EN) begin : g_ext
         logic [SYNC_STAGES-1:0] sync_q;
         logic                   prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q <= '1;
               prev_q <= 1'b1;
            end else begin
               sync_q <= {sync_q[SYNC_STAGES-2:0], sck_in};
               prev_q <= sync_q[SYNC_STAGES-1];
            end
         end
         assign e_fall = prev_q && !sync_q[SYNC_STAGES-1];
         assign e_rise = !prev_q && sync_q[SYNC_STAGES-1];
      end else begin : g_int_only
         assign e_fall = 1'b0;
         assign e_rise = 1'b0;
      end
   endgenerate

   assign sck_out  = sclk_q;
   assign fall_stb = ext_sel ? e_fall : i_fall;
   assign rise_stb = ext_sel ? e_rise : i_rise;

   assert_one_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(fall_stb && rise_stb));
   assert_pulse_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      npul <= LAST_PULSE);
   assert_div_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !tick) |=> $stable(sck_out));
   assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && sclk_q && npul == LAST_PULSE && !go) |=> (sck_out && !act));
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx #(
   parameter int unsigned CHAR_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 txe,
   input  logic                 fall,
   input  logic                 wr,
   input  logic [CHAR_BITS-1:0] wdata,
   output logic                 tde,
   output logic                 txd
);
   localparam int unsigned CW = $clog2(CHAR_BITS);
   localparam logic [CW-1:0] LAST_BIT = CW'(CHAR_BITS - 1);

   logic [CHAR_BITS-1:0] tdr, shr;
   logic                 busy;
   logic [CW-1:0]        bcnt;
   logic                 at_bound, load;

   assign at_bound = !busy || (bcnt == LAST_BIT);
   assign load     = fall && at_bound && txe && !tde;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tdr  <= '0;
         shr  <= '0;
         busy <= 1'b0;
         bcnt <= '0;
         tde  <= 1'b1;
         txd  <= 1'b1;
      end else begin
         if (wr) tdr <= wdata;
         if (wr)        tde <= 1'b0;
         else if (load) tde <= 1'b1;
         if (fall) begin
            if (load) begin
               shr  <= tdr;
               txd  <= tdr[0];
               busy <= 1'b1;
               bcnt <= '0;
            end else if (!at_bound) begin
               shr  <= shr >> 1;
               txd  <= shr[1];
               bcnt <= bcnt + 1'b1;
            end else begin
               busy <= 1'b0;
            end
         end
      end
   end

   assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !fall |=> $stable(txd));
   assert_tde_on_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !wr) |=> tde);
   assert_park_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && busy && bcnt == LAST_BIT && !load) |=> $stable(txd));
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx #(
   parameter int unsigned CHAR_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rxe,
   input  logic                 rise,
   input  logic                 rxd,
   input  logic                 rd,
   input  logic                 ovr_clr,
   output logic [CHAR_BITS-1:0] rdr,
   output logic                 rdf,
   output logic                 ovr
);
   localparam int unsigned CW = $clog2(CHAR_BITS);
   localparam logic [CW-1:0] LAST_BIT = CW'(CHAR_BITS - 1);

   logic [CHAR_BITS-1:0] shr;
   logic [CW-1:0]        bcnt;
   logic                 done;

   assign done = rise && rxe && (bcnt == LAST_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shr  <= '0;
         bcnt <= '0;
         rdr  <= '0;
         rdf  <= 1'b0;
         ovr  <= 1'b0;
      end else begin
         if (!rxe) begin
            bcnt <= '0;
         end else if (rise) begin
            shr  <= {rxd, shr[CHAR_BITS-1:1]};
            bcnt <= (bcnt == LAST_BIT) ? '0 : bcnt + 1'b1;
         end
         if (done && !rdf) rdr <= {rxd, shr[CHAR_BITS-1:1]};
         if (done && !rdf) rdf <= 1'b1;
         else if (rd)      rdf <= 1'b0;
         if (done && rdf)  ovr <= 1'b1;
         else if (ovr_clr) ovr <= 1'b0;
      end
   end

   assert_ovr_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rdf) |=> ovr);
   assert_ovr_keeps_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rdf) |=> $stable(rdr));
   assert_ovr_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !ovr_clr) |=> ovr);
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
   import ssp_pkg::*;
#(
   parameter int unsigned CHAR_BITS   = 8,
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          EXT_CLK_EN  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       host_wr,
   input  logic       host_rd,
   input  logic [2:0] host_addr,
   input  logic [7:0] host_wdata,
   output logic [7:0] host_rdata,
   input  logic       sck_i,
   output logic       sck_o,
   output logic       sck_oe,
   output logic       txd_o,
   input  logic       rxd_i
);
   generate
      if (CHAR_BITS < 2 || CHAR_BITS > HOST_DW) begin : g_bad_char
         $error("CHAR_BITS must lie between 2 and the host data width");
      end
      if (DIV_W < 1 || DIV_W > HOST_DW) begin : g_bad_div
         $error("DIV_W must lie between 1 and the host data width");
      end
      if (EXT_CLK_EN && SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   ssp_ctrl_t            ctrl;
   logic [DIV_W-1:0]     div;
   logic [CHAR_BITS-1:0] rx_char;
   logic                 tde, rdf, ovr;
   logic                 tdr_wr, rdr_rd, ovr_clr;
   logic                 fall_stb, rise_stb, req;

   assign req    = (ctrl.txe && !tde) || (ctrl.rxe && !ctrl.txe);
   assign sck_oe = !ctrl.ext;

   ssp_regs #(.CHAR_BITS(CHAR_BITS), .DIV_W(DIV_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(host_wr), .rd_en(host_rd),
      .addr(host_addr), .wdata(host_wdata), .rdata(host_rdata),
      .rx_char(rx_char), .tde(tde), .rdf(rdf), .ovr(ovr),
      .tdr_wr(tdr_wr), .rdr_rd(rdr_rd), .ovr_clr(ovr_clr),
      .div(div), .ctrl(ctrl)
   );

   ssp_clkgen #(.CHAR_BITS(CHAR_BITS), .DIV_W(DIV_W),
                .SYNC_STAGES(SYNC_STAGES), .EXT_CLK_EN(EXT_CLK_EN)) i_clkgen (
      .clk(clk), .rst_n(rst_n), .ext_sel(ctrl.ext), .req(req), .div(div),
      .sck_in(sck_i), .sck_out(sck_o), .fall_stb(fall_stb), .rise_stb(rise_stb)
   );

   ssp_tx #(.CHAR_BITS(CHAR_BITS)) i_tx (
      .clk(clk), .rst_n(rst_n), .txe(ctrl.txe), .fall(fall_stb),
      .wr(tdr_wr), .wdata(host_wdata[CHAR_BITS-1:0]), .tde(tde), .txd(txd_o)
   );

   ssp_rx #(.CHAR_BITS(CHAR_BITS)) i_rx (
      .clk(clk), .rst_n(rst_n), .rxe(ctrl.rxe), .rise(rise_stb), .rxd(rxd_i),
      .rd(rdr_rd), .ovr_clr(ovr_clr), .rdr(rx_char), .rdf(rdf), .ovr(ovr)
   );

   assert_ext_no_drive_R13: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.ext |-> !sck_oe);
   assert_tx_empty_before_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tdr_wr |=> !tde);
endmodule

// File: tb/test_sync_serial_port.sv
module test_sync_serial_port;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 4;
   // each entry: {byte sent by the port, byte sent by the far end}
   localparam logic [15:0] VEC [NVEC] = '{16'hA5_3C, 16'h00_FF, 16'hFF_00, 16'h01_80};

   logic clk = 1'b0, rst_n = 1'b0;
   logic host_wr = 1'b0, host_rd = 1'b0;
   logic [2:0] host_addr = '0;
   logic [7:0] host_wdata = '0, host_rdata;
   logic sck_i = 1'b1, sck_o, sck_oe, txd_o, rxd_i;
   logic sl_rxd = 1'b1, ext_rxd = 1'b1, ext_mode = 1'b0, sl_en = 1'b0;

   int n_chk = 0, n_err = 0;
   int cyc = 0, fall_cnt = 0, rise_cnt = 0, last_fall = 0;
   int fper [64];
   logic [7:0] sl_out [32];
   logic [7:0] cap [32];
   logic [7:0] cap_sh = '0;

   assign rxd_i = ext_mode ? ext_rxd : sl_rxd;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sync_serial_port i_sync_serial_port (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .txd_o(txd_o), .rxd_i(rxd_i)
   );

   // far end of the link on the internal clock
   always @(negedge sck_o) if (sl_en) begin
      sl_rxd = sl_out[(fall_cnt / 8) % 32][fall_cnt % 8];
      fper[fall_cnt % 64] = cyc - last_fall;
      last_fall = cyc;
      fall_cnt++;
   end
   always @(posedge sck_o) if (sl_en) begin
      cap_sh = {txd_o, cap_sh[7:1]};
      if (rise_cnt % 8 == 7) cap[(rise_cnt / 8) % 32] = cap_sh;
      rise_cnt++;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic hwr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk); host_wr = 1'b0;
   endtask

   task automatic hrd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); host_rd = 1'b1; host_addr = a;
      #1 d = host_rdata;
      @(negedge clk); host_rd = 1'b0;
   endtask

   task automatic poll(input int bitpos);
      logic [7:0] s;
      for (int k = 0; k < 400; k++) begin
         hrd(3'd2, s);
         if (s[bitpos]) break;
      end
   endtask

   task automatic wait_rises(input int target);
      for (int k = 0; k < 4000 && rise_cnt < target; k++) @(negedge clk);
   endtask

   task automatic summary;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      logic [7:0] d;
      int base, ch;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      sl_en = 1'b1;
      @(negedge clk);
      // R1 reset state
      hrd(3'd2, d);    chk("R1 status", d, 8'h01);
      chk("R1 sck_o", sck_o, 1'b1);
      chk("R1 sck_oe", sck_oe, 1'b1);
      chk("R1 txd", txd_o, 1'b1);
      hwr(3'd3, 8'd2);
      hwr(3'd4, 8'h03);

      // table walk: full duplex characters, R2 R3 R4 R5 R6 R7 R8 R9
      for (int i = 0; i < NVEC; i++) begin
         base = fall_cnt; ch = base / 8;
         sl_out[ch % 32] = VEC[i][7:0];
         hwr(3'd0, VEC[i][15:8]);
         wait_rises(base + 8);
         repeat (12) @(negedge clk);
         chk("R2 R3 sent byte", cap[ch % 32], VEC[i][15:8]);
         hrd(3'd2, d);   chk("R4 status", d, 8'h03);
         hrd(3'd0 + 3'd1, d); chk("R4 R8 received byte", d, VEC[i][7:0]);
         chk("R5 parked line", txd_o, VEC[i][15]);
         chk("R6 pulse count", fall_cnt - base, 8);
         chk("R7 idle high", sck_o, 1'b1);
         chk("R9 period N=2", fper[(base + 1) % 64], 6);
      end

      // R10 back-to-back transmit and receive
      base = fall_cnt; ch = base / 8;
      sl_out[ch % 32] = 8'h4B; sl_out[(ch + 1) % 32] = 8'hD2;
      hwr(3'd0, 8'h96);
      poll(0);
      hwr(3'd0, 8'h69);
      wait_rises(base + 8);
      poll(1);
      hrd(3'd1, d);   chk("R10 first received", d, 8'h4B);
      wait_rises(base + 16);
      repeat (12) @(negedge clk);
      chk("R10 first sent", cap[ch % 32], 8'h96);
      chk("R10 second sent", cap[(ch + 1) % 32], 8'h69);
      chk("R10 no gap", fper[(base + 8) % 64], 6);
      hrd(3'd2, d);   chk("R10 status", d, 8'h03);
      hrd(3'd1, d);   chk("R10 second received", d, 8'hD2);

      // R11 R12 overrun
      base = fall_cnt; ch = base / 8;
      sl_out[ch % 32] = 8'hC3; sl_out[(ch + 1) % 32] = 8'h5E;
      hwr(3'd0, 8'h11);
      poll(0);
      hwr(3'd0, 8'h22);
      wait_rises(base + 16);
      repeat (12) @(negedge clk);
      hrd(3'd2, d);   chk("R11 overrun status", d, 8'h07);
      hrd(3'd1, d);   chk("R11 old byte kept", d, 8'hC3);
      hrd(3'd2, d);   chk("R12 read keeps overrun", d, 8'h05);
      hwr(3'd2, 8'h03);
      hrd(3'd2, d);   chk("R12 write bit2=0 keeps overrun", d, 8'h05);
      hwr(3'd2, 8'h04);
      hrd(3'd2, d);   chk("R12 clear", d, 8'h01);

      // R9 divisor zero
      hwr(3'd3, 8'd0);
      base = fall_cnt; ch = base / 8;
      sl_out[ch % 32] = 8'hC5;
      hwr(3'd0, 8'h3A);
      wait_rises(base + 8);
      repeat (6) @(negedge clk);
      chk("R9 period N=0", fper[(base + 1) % 64], 2);
      chk("R9 sent at N=0", cap[ch % 32], 8'h3A);
      hrd(3'd1, d);   chk("R9 received at N=0", d, 8'hC5);
      hwr(3'd3, 8'd2);

      // R14 receive-only streaming
      base = fall_cnt; ch = base / 8;
      sl_out[ch % 32] = 8'h81; sl_out[(ch + 1) % 32] = 8'h42; sl_out[(ch + 2) % 32] = 8'h24;
      hwr(3'd4, 8'h02);
      poll(1);
      hrd(3'd1, d);   chk("R14 first", d, 8'h81);
      poll(1);
      hrd(3'd1, d);   chk("R14 second", d, 8'h42);
      hwr(3'd4, 8'h00);
      repeat (80) @(negedge clk);
      chk("R14 no gap", fper[(base + 8) % 64], 6);
      chk("R6 whole characters", fall_cnt % 8, 0);
      chk("R7 idle after stream", sck_o, 1'b1);
      hrd(3'd2, d);   chk("R14 status", d, 8'h01);

      // R13 external clock
      base = fall_cnt;
      hwr(3'd4, 8'h07);
      chk("R13 no drive", sck_oe, 1'b0);
      hwr(3'd0, 8'hB4);
      ext_mode = 1'b1;
      cap_sh = '0;
      for (int k = 0; k < 8; k++) begin
         sck_i = 1'b0;
         ext_rxd = 8'h6D >> k;
         repeat (8) @(negedge clk);
         cap_sh = {txd_o, cap_sh[7:1]};
         sck_i = 1'b1;
         repeat (8) @(negedge clk);
      end
      chk("R13 sent on external clock", cap_sh, 8'hB4);
      chk("R13 internal silent", fall_cnt - base, 0);
      hrd(3'd2, d);   chk("R13 status", d, 8'h03);
      hrd(3'd1, d);   chk("R13 received on external clock", d, 8'h6D);
      summary();
   end
endmodule